// File: doc/BRIEF.md
# Group Trigger Dispatcher

This block takes start requests for up to 32 transfer groups and files each accepted request into one of two pending lists, a synchronous one and an asynchronous one, for a transfer engine to consume later. A request can arrive on a per-group hardware trigger line or through a software trigger word. A per-group definition word chooses the destination list and the descriptor source. For deterministic groups, it also holds a descriptor start address.

A group holds at most one pending request at a time. A request for a group already waiting, either in the arbitration stage or in a list, is dropped and reported on a one-cycle error pulse. When several requests arrive together, a pending bit vector records them and a priority picker moves them into the lists one per cycle, lowest group index first. Each list presents its oldest entry on a valid/ready port and reports its fill level. Popping an entry releases the group so it can be triggered again.

Top module: `trig_dispatch`

## Requirements
- R1: After reset both list levels are 0, both pop-valid outputs are low and the error output is low.
- R2: A software trigger word with bit n set starts group n. Zero bits start nothing, and a word of all zeros changes neither level.
- R3: A software trigger for a group whose definition has bit 13 = 1 (non-deterministic source) is ignored: no list entry and no error pulse.
- R4: A hardware trigger line starts its group whatever the descriptor source bit says.
- R5: Definition bit 12 = 1 routes the group to the asynchronous list; bit 12 = 0 routes it to the synchronous list.
- R6: A list entry carries the group index, definition bits 11:0 as start address and bit 13 as source flag, all taken from the definition in force on the trigger cycle. Later writes to the definition do not alter an entry.
- R7: A trigger for a group already awaiting entry or sitting in a list creates no second entry. It drives the error output high for exactly the cycle after the trigger edge.
- R8: Triggers that arrive together enter the lists one per cycle in ascending group index. The first entry appears one cycle after the trigger edge.
- R9: An entry leaves its list on a cycle where valid and ready are both high, which ends the group's pending state. A trigger on that same cycle is accepted without error.
- R10: Each level output equals the entry count of its list, never exceeding LIST_DEPTH (8 by default, 4-bit level). Requests for a full list wait and are entered in order once space frees, none lost.
- R11: A software and a hardware trigger for the same group on the same cycle count as one request with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| defWrEn | input | 1 | Definition write strobe |
| defWrIdx | input | 5 | Group whose definition is written |
| defWrData | input | 14 | Definition word: [13] non-deterministic source, [12] asynchronous list, [11:0] start address |
| swTrigValid | input | 1 | Software trigger word strobe |
| swTrigBits | input | 32 | Software trigger word, one bit per group |
| hwTrig | input | 32 | Hardware trigger lines, one per group, active high per cycle |
| syncPopReady | input | 1 | Consumer takes the synchronous head entry |
| syncPopValid | output | 1 | Synchronous list not empty |
| syncPopGroup | output | 5 | Group index of synchronous head |
| syncPopAddr | output | 12 | Start address of synchronous head |
| syncPopNonDet | output | 1 | Source flag of synchronous head |
| asyncPopReady | input | 1 | Consumer takes the asynchronous head entry |
| asyncPopValid | output | 1 | Asynchronous list not empty |
| asyncPopGroup | output | 5 | Group index of asynchronous head |
| asyncPopAddr | output | 12 | Start address of asynchronous head |
| asyncPopNonDet | output | 1 | Source flag of asynchronous head |
| syncLevel | output | 4 | Synchronous list entry count |
| asyncLevel | output | 4 | Asynchronous list entry count |
| retrigErr | output | 1 | One-cycle pulse on a trigger of a pending group |

## Verification
Two pairs of events can share a cycle. A trigger can coincide with the pop of that same group, and a software trigger can coincide with a hardware trigger of the same group. The bench provokes the first by raising the trigger line and the pop ready together while the group is the only list head. It then expects no error pulse, a level of 0 after that edge and a fresh entry of that group one cycle later. For the second, it drives both sources for one group on one cycle and expects one entry and a silent error output. Requests held back behind a full list are judged by the full pop order.

// File: rtl/trd_pkg.sv
package trd_pkg;
  localparam int NUM_GRP = 32;
  localparam int GRP_W   = $clog2(NUM_GRP);
  localparam int ADDR_W  = 12;
  localparam int DEF_W   = ADDR_W + 2;

  // Definition word layout: source flag on top, list select, start address.
  typedef struct packed {
    logic              nonDet;
    logic              toAsync;
    logic [ADDR_W-1:0] startAddr;
  } grpDef_t;

  typedef struct packed {
    logic [GRP_W-1:0]  grp;
    logic              nonDet;
    logic [ADDR_W-1:0] startAddr;
  } listEntry_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic               push;
    logic               toAsync;
    logic [GRP_W-1:0]   pushGrp;
    logic [NUM_GRP-1:0] capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/trd_list.sv
module trd_list
  import trd_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  listEntry_t       pushEntry,
  input  logic             popReady,
  output logic             popValid,
  output listEntry_t       headEntry,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  listEntry_t mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic pushDo, popDo;

  assign full      = (count == LVL_W'(DEPTH));
  assign popValid  = (count != '0);
  assign headEntry = mem[rdPtr];
  assign level     = count;
  assign popDo     = popReady && popValid;
  assign pushDo    = pushEn && !full;

  always_ff @(posedge clk) begin
    if (pushDo) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushDo) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (popDo)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      if (pushDo && !popDo)      count <= count + LVL_W'(1);
      else if (popDo && !pushDo) count <= count - LVL_W'(1);
    end
  end
endmodule

// File: rtl/trd_ctrl.sv
module trd_ctrl
  import trd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               swTrigValid,
  input  logic [NUM_GRP-1:0] swTrigBits,
  input  logic [NUM_GRP-1:0] hwTrig,
  input  logic [NUM_GRP-1:0] nonDetNow,
  input  logic [NUM_GRP-1:0] toAsyncSnap,
  input  logic               syncFull,
  input  logic               asyncFull,
  input  logic               syncPopDone,
  input  logic [GRP_W-1:0]   syncPopGrp,
  input  logic               asyncPopDone,
  input  logic [GRP_W-1:0]   asyncPopGrp,
  output ctrlStrobe_t        strb,
  output logic               retrigErr
);
  logic [NUM_GRP-1:0] reqVec, queuedVec;
  logic [NUM_GRP-1:0] trigIn, popMask, pendNow, acceptVec, eligible, grantVec;
  logic [GRP_W-1:0]   grantIdx;
  logic               found, clash;

  // Software triggers only reach deterministic groups.
  assign trigIn = hwTrig | (swTrigValid ? (swTrigBits & ~nonDetNow) : '0);

  always_comb begin
    popMask = '0;
    if (syncPopDone)  popMask[syncPopGrp]  = 1'b1;
    if (asyncPopDone) popMask[asyncPopGrp] = 1'b1;
  end

  // A group popped this cycle no longer counts as pending.
  assign pendNow   = reqVec | (queuedVec & ~popMask);
  assign acceptVec = trigIn & ~pendNow;
  assign clash     = |(trigIn & pendNow);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_elig
    assign eligible[g] = reqVec[g] & (toAsyncSnap[g] ? ~asyncFull : ~syncFull);
  end

  always_comb begin
    grantVec = '0;
    grantIdx = '0;
    found    = 1'b0;
    for (int n = 0; n < NUM_GRP; n++) begin
      if (eligible[n] && !found) begin
        grantVec[n] = 1'b1;
        grantIdx    = GRP_W'(n);
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    strb.push    = found;
    strb.toAsync = toAsyncSnap[grantIdx];
    strb.pushGrp = grantIdx;
    strb.capture = acceptVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqVec    <= '0;
      queuedVec <= '0;
      retrigErr <= 1'b0;
    end else begin
      reqVec    <= (reqVec & ~grantVec) | acceptVec;
      queuedVec <= (queuedVec & ~popMask) | grantVec;
      retrigErr <= clash;
    end
  end
endmodule

// File: rtl/trd_data.sv
module trd_data
  import trd_pkg::*;
#(
  parameter int LIST_DEPTH = 8,
  localparam int LVL_W = $clog2(LIST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               defWrEn,
  input  logic [GRP_W-1:0]   defWrIdx,
  input  grpDef_t            defWrData,
  input  ctrlStrobe_t        strb,
  input  logic               syncPopReady,
  input  logic               asyncPopReady,
  output logic [NUM_GRP-1:0] nonDetNow,
  output logic [NUM_GRP-1:0] toAsyncSnap,
  output logic               syncFull,
  output logic               asyncFull,
  output logic               syncPopDone,
  output logic               asyncPopDone,
  output logic               syncValid,
  output logic               asyncValid,
  output listEntry_t         syncHead,
  output listEntry_t         asyncHead,
  output logic [LVL_W-1:0]   syncLevel,
  output logic [LVL_W-1:0]   asyncLevel
);
  grpDef_t defReg  [NUM_GRP];
  grpDef_t snapReg [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        defReg[g]  <= '0;
        snapReg[g] <= '0;
      end else begin
        if (defWrEn && (defWrIdx == GRP_W'(g))) defReg[g] <= defWrData;
        if (strb.capture[g]) snapReg[g] <= defReg[g];
      end
    end
    assign nonDetNow[g]   = defReg[g].nonDet;
    assign toAsyncSnap[g] = snapReg[g].toAsync;
  end

  listEntry_t pushEntry;
  assign pushEntry.grp       = strb.pushGrp;
  assign pushEntry.nonDet    = snapReg[strb.pushGrp].nonDet;
  assign pushEntry.startAddr = snapReg[strb.pushGrp].startAddr;

  // Index 0 is the synchronous list, index 1 the asynchronous list.
  logic [1:0]       pushVec, readyVec, validVec, fullVec;
  listEntry_t       headArr [2];
  logic [LVL_W-1:0] levelArr [2];

  assign pushVec  = {strb.push & strb.toAsync, strb.push & ~strb.toAsync};
  assign readyVec = {asyncPopReady, syncPopReady};

  for (genvar l = 0; l < 2; l++) begin : g_list
    trd_list #(.DEPTH(LIST_DEPTH)) u_list (
      .clk       (clk),
      .rstN      (rstN),
      .pushEn    (pushVec[l]),
      .pushEntry (pushEntry),
      .popReady  (readyVec[l]),
      .popValid  (validVec[l]),
      .headEntry (headArr[l]),
      .full      (fullVec[l]),
      .level     (levelArr[l])
    );
  end

  assign syncValid    = validVec[0];
  assign asyncValid   = validVec[1];
  assign syncFull     = fullVec[0];
  assign asyncFull    = fullVec[1];
  assign syncHead     = headArr[0];
  assign asyncHead    = headArr[1];
  assign syncLevel    = levelArr[0];
  assign asyncLevel   = levelArr[1];
  assign syncPopDone  = validVec[0] & readyVec[0];
  assign asyncPopDone = validVec[1] & readyVec[1];
endmodule

// File: rtl/trig_dispatch.sv
module trig_dispatch
  import trd_pkg::*;
#(
  parameter int LIST_DEPTH = 8,
  localparam int LVL_W = $clog2(LIST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               defWrEn,
  input  logic [GRP_W-1:0]   defWrIdx,
  input  logic [DEF_W-1:0]   defWrData,
  input  logic               swTrigValid,
  input  logic [NUM_GRP-1:0] swTrigBits,
  input  logic [NUM_GRP-1:0] hwTrig,
  input  logic               syncPopReady,
  output logic               syncPopValid,
  output logic [GRP_W-1:0]   syncPopGroup,
  output logic [ADDR_W-1:0]  syncPopAddr,
  output logic               syncPopNonDet,
  input  logic               asyncPopReady,
  output logic               asyncPopValid,
  output logic [GRP_W-1:0]   asyncPopGroup,
  output logic [ADDR_W-1:0]  asyncPopAddr,
  output logic               asyncPopNonDet,
  output logic [LVL_W-1:0]   syncLevel,
  output logic [LVL_W-1:0]   asyncLevel,
  output logic               retrigErr
);
  ctrlStrobe_t        strb;
  logic [NUM_GRP-1:0] nonDetNow, toAsyncSnap;
  logic               syncFull, asyncFull, syncPopDone, asyncPopDone;
  listEntry_t         syncHead, asyncHead;

  trd_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .swTrigValid  (swTrigValid),
    .swTrigBits   (swTrigBits),
    .hwTrig       (hwTrig),
    .nonDetNow    (nonDetNow),
    .toAsyncSnap  (toAsyncSnap),
    .syncFull     (syncFull),
    .asyncFull    (asyncFull),
    .syncPopDone  (syncPopDone),
    .syncPopGrp   (syncHead.grp),
    .asyncPopDone (asyncPopDone),
    .asyncPopGrp  (asyncHead.grp),
    .strb         (strb),
    .retrigErr    (retrigErr)
  );

  trd_data #(.LIST_DEPTH(LIST_DEPTH)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .defWrEn       (defWrEn),
    .defWrIdx      (defWrIdx),
    .defWrData     (grpDef_t'(defWrData)),
    .strb          (strb),
    .syncPopReady  (syncPopReady),
    .asyncPopReady (asyncPopReady),
    .nonDetNow     (nonDetNow),
    .toAsyncSnap   (toAsyncSnap),
    .syncFull      (syncFull),
    .asyncFull     (asyncFull),
    .syncPopDone   (syncPopDone),
    .asyncPopDone  (asyncPopDone),
    .syncValid     (syncPopValid),
    .asyncValid    (asyncPopValid),
    .syncHead      (syncHead),
    .asyncHead     (asyncHead),
    .syncLevel     (syncLevel),
    .asyncLevel    (asyncLevel)
  );

  assign syncPopGroup   = syncHead.grp;
  assign syncPopAddr    = syncHead.startAddr;
  assign syncPopNonDet  = syncHead.nonDet;
  assign asyncPopGroup  = asyncHead.grp;
  assign asyncPopAddr   = asyncHead.startAddr;
  assign asyncPopNonDet = asyncHead.nonDet;
endmodule

// File: rtl/trd_checker.sv
module trd_checker
  import trd_pkg::*;
#(
  parameter int LIST_DEPTH = 8,
  localparam int LVL_W = $clog2(LIST_DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               swTrigValid,
  input logic [NUM_GRP-1:0] hwTrig,
  input logic               syncPopReady,
  input logic               syncPopValid,
  input logic [GRP_W-1:0]   syncPopGroup,
  input logic [ADDR_W-1:0]  syncPopAddr,
  input logic               asyncPopReady,
  input logic               asyncPopValid,
  input logic [GRP_W-1:0]   asyncPopGroup,
  input logic [ADDR_W-1:0]  asyncPopAddr,
  input logic [LVL_W-1:0]   syncLevel,
  input logic [LVL_W-1:0]   asyncLevel,
  input logic               retrigErr
);
  a_r7_err_follows_trigger: assert property (@(posedge clk) disable iff (!rstN)
    retrigErr |-> $past(swTrigValid || (|hwTrig)));

  a_r10_sync_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(syncLevel) <= LIST_DEPTH);

  a_r10_async_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(asyncLevel) <= LIST_DEPTH);

  a_r10_sync_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncLevel) |-> (int'(syncLevel) == int'($past(syncLevel)) + 1 ||
                             int'(syncLevel) + 1 == int'($past(syncLevel))));

  a_r8_one_entry_per_cycle: assert property (@(posedge clk) disable iff (!rstN)
    int'(syncLevel) + int'(asyncLevel) <= int'($past(syncLevel)) + int'($past(asyncLevel)) + 1);

  a_r9_sync_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (syncPopValid && !syncPopReady) |=> (syncPopValid && $stable(syncPopGroup) && $stable(syncPopAddr)));

  a_r9_async_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (asyncPopValid && !asyncPopReady) |=> (asyncPopValid && $stable(asyncPopGroup) && $stable(asyncPopAddr)));
endmodule

bind trig_dispatch trd_checker #(.LIST_DEPTH(LIST_DEPTH)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .swTrigValid   (swTrigValid),
  .hwTrig        (hwTrig),
  .syncPopReady  (syncPopReady),
  .syncPopValid  (syncPopValid),
  .syncPopGroup  (syncPopGroup),
  .syncPopAddr   (syncPopAddr),
  .asyncPopReady (asyncPopReady),
  .asyncPopValid (asyncPopValid),
  .asyncPopGroup (asyncPopGroup),
  .asyncPopAddr  (asyncPopAddr),
  .syncLevel     (syncLevel),
  .asyncLevel    (asyncLevel),
  .retrigErr     (retrigErr)
);

// File: tb/sim_trig_dispatch.sv
module sim_trig_dispatch;
  import trd_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic defWrEn = 1'b0;
  logic [GRP_W-1:0] defWrIdx = '0;
  logic [DEF_W-1:0] defWrData = '0;
  logic swTrigValid = 1'b0;
  logic [NUM_GRP-1:0] swTrigBits = '0;
  logic [NUM_GRP-1:0] hwTrig = '0;
  logic syncPopReady = 1'b0, asyncPopReady = 1'b0;
  logic syncPopValid, asyncPopValid, syncPopNonDet, asyncPopNonDet, retrigErr;
  logic [GRP_W-1:0] syncPopGroup, asyncPopGroup;
  logic [ADDR_W-1:0] syncPopAddr, asyncPopAddr;
  logic [3:0] syncLevel, asyncLevel;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trig_dispatch u0 (
    .clk(clk), .rstN(rstN), .defWrEn(defWrEn), .defWrIdx(defWrIdx), .defWrData(defWrData),
    .swTrigValid(swTrigValid), .swTrigBits(swTrigBits), .hwTrig(hwTrig),
    .syncPopReady(syncPopReady), .syncPopValid(syncPopValid), .syncPopGroup(syncPopGroup),
    .syncPopAddr(syncPopAddr), .syncPopNonDet(syncPopNonDet),
    .asyncPopReady(asyncPopReady), .asyncPopValid(asyncPopValid), .asyncPopGroup(asyncPopGroup),
    .asyncPopAddr(asyncPopAddr), .asyncPopNonDet(asyncPopNonDet),
    .syncLevel(syncLevel), .asyncLevel(asyncLevel), .retrigErr(retrigErr)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic defWrite(int g, bit nd, bit as, int addr);
    defWrEn = 1'b1;
    defWrIdx = GRP_W'(g);
    defWrData = {nd, as, ADDR_W'(addr)};
    cyc(1);
    defWrEn = 1'b0;
  endtask

  task automatic hwPulse(logic [NUM_GRP-1:0] v);
    hwTrig = v;
    cyc(1);
    hwTrig = '0;
  endtask

  task automatic swPulse(logic [NUM_GRP-1:0] v);
    swTrigValid = 1'b1;
    swTrigBits = v;
    cyc(1);
    swTrigValid = 1'b0;
    swTrigBits = '0;
  endtask

  task automatic popOne(bit isAsync, output int grp, output int addr, output int nd);
    if (isAsync) begin
      grp = int'(asyncPopGroup); addr = int'(asyncPopAddr); nd = int'(asyncPopNonDet);
      asyncPopReady = 1'b1; cyc(1); asyncPopReady = 1'b0;
    end else begin
      grp = int'(syncPopGroup); addr = int'(syncPopAddr); nd = int'(syncPopNonDet);
      syncPopReady = 1'b1; cyc(1); syncPopReady = 1'b0;
    end
  endtask

  task automatic tReset();
    chk("R1 syncLevel", int'(syncLevel), 0);
    chk("R1 asyncLevel", int'(asyncLevel), 0);
    chk("R1 syncPopValid", int'(syncPopValid), 0);
    chk("R1 asyncPopValid", int'(asyncPopValid), 0);
    chk("R1 retrigErr", int'(retrigErr), 0);
  endtask

  task automatic tSoftware();
    int g, a, n;
    defWrite(5, 1'b0, 1'b0, 'h123);
    swPulse(32'h1 << 5);
    cyc(1);
    chk("R2 sync level after sw trigger", int'(syncLevel), 1);
    chk("R5 async level untouched", int'(asyncLevel), 0);
    popOne(1'b0, g, a, n);
    chk("R2 group index", g, 5);
    chk("R6 start addr", a, 'h123);
    chk("R6 source flag", n, 0);
    swPulse('0);
    cyc(2);
    chk("R2 zero word sync level", int'(syncLevel), 0);
    chk("R2 zero word async level", int'(asyncLevel), 0);
  endtask

  task automatic tSwNonDet();
    defWrite(7, 1'b1, 1'b0, 'h055);
    swPulse(32'h1 << 7);
    chk("R3 no error for ignored sw trigger", int'(retrigErr), 0);
    cyc(3);
    chk("R3 sync level", int'(syncLevel), 0);
    chk("R3 async level", int'(asyncLevel), 0);
  endtask

  task automatic tHwAsync();
    int g, a, n;
    defWrite(7, 1'b1, 1'b1, 'hABC);
    hwPulse(32'h1 << 7);
    defWrite(7, 1'b0, 1'b0, 'h001);
    chk("R4 async level after hw trigger", int'(asyncLevel), 1);
    chk("R5 sync level", int'(syncLevel), 0);
    popOne(1'b1, g, a, n);
    chk("R4 group index", g, 7);
    chk("R6 captured addr", a, 'hABC);
    chk("R6 captured source", n, 1);
  endtask

  task automatic tRetrigger();
    int g, a, n;
    hwPulse(32'h1 << 9);
    chk("R7 first trigger no error", int'(retrigErr), 0);
    hwPulse(32'h1 << 9);
    chk("R7 error while awaiting entry", int'(retrigErr), 1);
    cyc(1);
    chk("R7 error one cycle", int'(retrigErr), 0);
    chk("R7 single entry", int'(syncLevel), 1);
    hwPulse(32'h1 << 9);
    chk("R7 error while in list", int'(retrigErr), 1);
    cyc(2);
    chk("R7 still single entry", int'(syncLevel), 1);
    popOne(1'b0, g, a, n);
    chk("R9 level after pop", int'(syncLevel), 0);
    hwPulse(32'h1 << 9);
    chk("R9 trigger after pop accepted", int'(retrigErr), 0);
    cyc(1);
    popOne(1'b0, g, a, n);
    chk("R9 regained group", g, 9);
  endtask

  task automatic tPopAndTrigger();
    int g, a, n;
    hwPulse(32'h1 << 11);
    cyc(1);
    chk("R9 setup level", int'(syncLevel), 1);
    hwTrig = 32'h1 << 11;
    syncPopReady = 1'b1;
    cyc(1);
    hwTrig = '0;
    syncPopReady = 1'b0;
    chk("R9 no error on same-cycle pop", int'(retrigErr), 0);
    chk("R9 level right after pop", int'(syncLevel), 0);
    cyc(1);
    chk("R9 re-entered", int'(syncLevel), 1);
    popOne(1'b0, g, a, n);
    chk("R9 re-entered group", g, 11);
  endtask

  task automatic tDualSource();
    int g, a, n;
    hwTrig = 32'h1 << 13;
    swTrigValid = 1'b1;
    swTrigBits = 32'h1 << 13;
    cyc(1);
    hwTrig = '0; swTrigValid = 1'b0; swTrigBits = '0;
    chk("R11 no error", int'(retrigErr), 0);
    cyc(3);
    chk("R11 one entry", int'(syncLevel), 1);
    popOne(1'b0, g, a, n);
    chk("R11 group", g, 13);
  endtask

  task automatic tBurstFull();
    int seq[$];
    int maxLvl = 0;
    hwPulse(32'h03FF_0000);
    cyc(12);
    chk("R10 level at capacity", int'(syncLevel), 8);
    chk("R10 async untouched", int'(asyncLevel), 0);
    syncPopReady = 1'b1;
    for (int c = 0; c < 24; c++) begin
      if (int'(syncLevel) > maxLvl) maxLvl = int'(syncLevel);
      if (syncPopValid) seq.push_back(int'(syncPopGroup));
      cyc(1);
    end
    syncPopReady = 1'b0;
    chk("R10 level never above depth", maxLvl, 8);
    chk("R10 no request lost", seq.size(), 10);
    for (int i = 0; i < seq.size() && i < 10; i++) chk("R8 ascending order", seq[i], 16 + i);
    chk("R10 drained", int'(syncLevel), 0);
  endtask

  task automatic tMixedLists();
    int g, a, n;
    defWrite(2, 1'b0, 1'b1, 'h222);
    hwPulse(32'h0000_000C);
    cyc(1);
    chk("R8 lowest index first (async)", int'(asyncLevel), 1);
    chk("R8 second not yet entered", int'(syncLevel), 0);
    cyc(1);
    chk("R8 second entered next cycle", int'(syncLevel), 1);
    popOne(1'b1, g, a, n);
    chk("R5 async group", g, 2);
    popOne(1'b0, g, a, n);
    chk("R5 sync group", g, 3);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    tReset();
    tSoftware();
    tSwNonDet();
    tHwAsync();
    tRetrigger();
    tPopAndTrigger();
    tDualSource();
    tBurstFull();
    tMixedLists();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule